// File: doc/BRIEF.md
# Three-Level Nested Interrupt Controller

This block sits beside a small 8-bit processor core. It takes the raw request flags of the surrounding peripherals and decides which one the core services next. The sources are a power-fail warning, two external interrupt lines, two timer overflows and a serial port that raises separate transmit-done and receive-done flags. A byte-wide register port gives software read and write access to an enable register and a priority register.

Each ordinary source can be set to low or high priority. The power-fail warning always sits at a third level above both, and is gated only by its own enable pin. The controller keeps a small stack of the levels that are in service. A new request is offered to the core only when its level is strictly above the highest level in service. The request goes out as a single level-held strobe with a 16-bit vector. When the core accepts it with an acknowledge, the granted level is pushed onto the stack. When the core signals a return from interrupt, the topmost level is popped.

Top module: `intr_nest_ctrl`

## Requirements
- R1: `reg_sel`=0 selects the enable register and `reg_sel`=1 selects the priority register. A write takes effect at the clock edge where `reg_we` is 1. `reg_rdata` shows the selected register at all times, and both registers read 0 after reset. Enable bit layout: bit 7 global, bit 4 serial, bit 3 timer 1, bit 2 external 1, bit 1 timer 0, bit 0 external 0; bits 6 and 5 read 0. The priority register uses the same bit positions for bits 4..0, where 1 means high, and bits 7..5 read 0.
- R2: While the global enable is 0, no source except the power-fail warning raises a request. The power-fail warning is gated only by `pf_en` and ignores the enable register.
- R3: With the global enable set, each ordinary source needs its own enable bit. The serial source is pending when `ser_tx_flag` or `ser_rx_flag` is 1.
- R4: The power-fail warning is at the top level. An ordinary source is at high level when its priority bit is 1, otherwise at low level. When requests of different levels are pending together, the higher level is offered.
- R5: Within one level, ties go in this order: power-fail, external 0, timer 0, external 1, timer 1, serial.
- R6: `irq_vec` is 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for timer 1, 0x0023 for serial and 0x0033 for power-fail.
- R7: `irq_req` rises one clock after an eligible request is seen. While it waits for `irq_ack`, it and `irq_vec` stay constant, whatever the sources do.
- R8: An `irq_ack` while `irq_req` is 1 pushes the offered level into service and drops `irq_req` on the same edge. An `irq_ack` while `irq_req` is 0 has no effect.
- R9: A request is offered only if its level is strictly above the highest level in service. Low cannot preempt low, high cannot preempt high, and power-fail preempts high or low.
- R10: An `irq_ret` pulse removes the highest level in service. With nothing in service, it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = enable register, 1 = priority register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| pf_warn | input | 1 | Power-fail warning request |
| pf_en | input | 1 | Power-fail enable |
| ext0_flag | input | 1 | External 0 request flag |
| tmr0_flag | input | 1 | Timer 0 overflow flag |
| ext1_flag | input | 1 | External 1 request flag |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| ser_tx_flag | input | 1 | Serial transmit-done flag |
| ser_rx_flag | input | 1 | Serial receive-done flag |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 16 | Vector of the offered source |
| irq_ack | input | 1 | Core accepts the offered request |
| irq_ret | input | 1 | Core returned from a service routine |

## Verification
A wrong bit in the in-service stack cannot be read directly. It shows up as a request that is wrongly offered or wrongly withheld, on the first edge where a source of a neighbouring level is pending. That can be many cycles after the bad push or pop. The bench therefore checks `irq_req` and `irq_vec` on every clock against a behavioural model of the stack. Each directed scenario stacks low, high and power-fail service in turn, then unwinds it with return pulses, so that a stale level blocks or releases a request within one or two clocks of the return that should have changed it.

// File: rtl/inc_pkg.sv
package inc_pkg;
  localparam int NUM_SRC   = 5;
  localparam int NUM_LVL   = 3;
  localparam int IDX_W     = 3;
  localparam int LVL_W     = 2;
  localparam int RANK_W    = 2;
  localparam int VEC_W     = 16;
  localparam int DATA_W    = 8;
  localparam int GLB_BIT   = 7;
  localparam logic [IDX_W-1:0] PF_IDX = 3'd6;

  typedef enum logic [LVL_W-1:0] {
    LVL_LOW  = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_PF   = 2'd2
  } lvl_e;

  // vector = index * 8 + 3
  function automatic logic [VEC_W-1:0] src_vector(input logic [IDX_W-1:0] idx);
    logic [VEC_W-1:0] v;
    v = '0;
    v[IDX_W+2:3] = idx;
    v[2:0] = 3'b011;
    return v;
  endfunction
endpackage

// File: rtl/inc_regfile.sv
module inc_regfile
  import inc_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int DW    = DATA_W,
  parameter int GBIT  = GLB_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [N_SRC-1:0] src_en,
  output logic          glb_en,
  output logic [N_SRC-1:0] src_hi
);
  logic [N_SRC-1:0] en_q, en_d, pr_q, pr_d;
  logic             gen_q, gen_d;
  logic             en_ce, pr_ce;

  assign en_ce = wr_en & ~sel;
  assign pr_ce = wr_en &  sel;

  always_comb begin
    en_d  = en_q;
    gen_d = gen_q;
    pr_d  = pr_q;
    if (en_ce) begin
      en_d  = wr_data[N_SRC-1:0];
      gen_d = wr_data[GBIT];
    end
    if (pr_ce) pr_d = wr_data[N_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      gen_q <= 1'b0;
      pr_q  <= '0;
    end else begin
      en_q  <= en_d;
      gen_q <= gen_d;
      pr_q  <= pr_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (sel) begin
      rd_data[N_SRC-1:0] = pr_q;
    end else begin
      rd_data[N_SRC-1:0] = en_q;
      rd_data[GBIT]      = gen_q;
    end
  end

  assign src_en = en_q;
  assign glb_en = gen_q;
  assign src_hi = pr_q;

  // R1
  enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel) |=> (glb_en == $past(wr_data[GBIT])) && (src_en == $past(wr_data[N_SRC-1:0])));
endmodule

// File: rtl/inc_arbiter.sv
module inc_arbiter
  import inc_pkg::*;
#(
  parameter int N_SRC = NUM_SRC
) (
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] hi,
  input  logic             pf_pend,
  output logic             cand_vld,
  output lvl_e             cand_lvl,
  output logic [IDX_W-1:0] cand_idx
);
  logic any_hi;
  logic [IDX_W-1:0] win;

  assign any_hi = |(pend & hi);

  // scan from the last source down so the lowest index wins
  always_comb begin
    win = '0;
    for (int i = N_SRC-1; i >= 0; i--) begin
      if (pend[i] && (hi[i] == any_hi)) win = IDX_W'(i);
    end
  end

  always_comb begin
    if (pf_pend) begin
      cand_vld = 1'b1;
      cand_lvl = LVL_PF;
      cand_idx = PF_IDX;
    end else begin
      cand_vld = |pend;
      cand_lvl = any_hi ? LVL_HIGH : LVL_LOW;
      cand_idx = win;
    end
  end
endmodule

// File: rtl/inc_service_stack.sv
module inc_service_stack
  import inc_pkg::*;
#(
  parameter int N_LVL = NUM_LVL,
  parameter int RW    = RANK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [N_LVL-1:0] act,
  output logic [RW-1:0]    top_rank
);
  logic [N_LVL-1:0] act_q, act_d, popped;
  logic             act_ce;

  always_comb begin
    popped = act_q;
    if (pop) begin
      for (int i = 0; i < N_LVL; i++) begin
        if (act_q[i] && ((act_q >> (i+1)) == '0)) popped[i] = 1'b0;
      end
    end
  end

  assign act_ce = push | pop;

  always_comb begin
    act_d = act_q;
    if (act_ce) begin
      act_d = popped;
      for (int i = 0; i < N_LVL; i++) begin
        if (push && (push_lvl == LVL_W'(i))) act_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  always_comb begin
    top_rank = '0;
    for (int i = 0; i < N_LVL; i++) begin
      if (act_q[i]) top_rank = RW'(i+1);
    end
  end

  assign act = act_q;

  // R8
  push_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> act[$past(push_lvl)]);
  // R10
  pop_removes_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && act != '0) |=> ($countones(act) + 1 == $countones($past(act))));
  // R10
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && act == '0) |=> (act == '0));
endmodule

// File: rtl/intr_nest_ctrl.sv
module intr_nest_ctrl
  import inc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pf_warn,
  input  logic              pf_en,
  input  logic              ext0_flag,
  input  logic              tmr0_flag,
  input  logic              ext1_flag,
  input  logic              tmr1_flag,
  input  logic              ser_tx_flag,
  input  logic              ser_rx_flag,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack,
  input  logic              irq_ret
);
  logic [NUM_SRC-1:0] src_en, src_hi, raw, pend;
  logic               glb_en, pf_pend;
  logic               cand_vld;
  lvl_e               cand_lvl;
  logic [IDX_W-1:0]   cand_idx;
  logic [RANK_W-1:0]  cand_rank, top_rank, req_rank;
  logic [NUM_LVL-1:0] act;

  logic               req_q, req_d;
  logic [VEC_W-1:0]   vec_q, vec_d;
  lvl_e               lvl_q, lvl_d;
  logic               fire, take;

  inc_regfile i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .sel(reg_sel),
    .wr_data(reg_wdata), .rd_data(reg_rdata),
    .src_en(src_en), .glb_en(glb_en), .src_hi(src_hi)
  );

  assign raw     = {ser_tx_flag | ser_rx_flag, tmr1_flag, ext1_flag, tmr0_flag, ext0_flag};
  assign pend    = raw & src_en & {NUM_SRC{glb_en}};
  assign pf_pend = pf_warn & pf_en;

  inc_arbiter i_arb (
    .pend(pend), .hi(src_hi), .pf_pend(pf_pend),
    .cand_vld(cand_vld), .cand_lvl(cand_lvl), .cand_idx(cand_idx)
  );

  assign cand_rank = RANK_W'(cand_lvl) + RANK_W'(1);
  assign fire = !req_q && cand_vld && (cand_rank > top_rank);
  assign take = req_q && irq_ack;

  inc_service_stack i_stack (
    .clk(clk), .rst_n(rst_n), .push(take), .push_lvl(lvl_q),
    .pop(irq_ret), .act(act), .top_rank(top_rank)
  );

  always_comb begin
    req_d = req_q;
    vec_d = vec_q;
    lvl_d = lvl_q;
    if (fire) begin
      req_d = 1'b1;
      vec_d = src_vector(cand_idx);
      lvl_d = cand_lvl;
    end else if (take) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= LVL_LOW;
    end else begin
      req_q <= req_d;
      vec_q <= vec_d;
      lvl_q <= lvl_d;
    end
  end

  assign irq_req  = req_q;
  assign irq_vec  = vec_q;
  assign req_rank = RANK_W'(lvl_q) + RANK_W'(1);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));
  // R8
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> !irq_req);
  // R9
  preempt_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> (req_rank > top_rank));
  // R2
  global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_req) && !$past(glb_en)) |-> (irq_vec == src_vector(PF_IDX)));
endmodule

// File: tb/test_intr_nest_ctrl.sv
module test_intr_nest_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic pf_warn = 0, pf_en = 0;
  logic ext0_flag = 0, tmr0_flag = 0, ext1_flag = 0, tmr1_flag = 0;
  logic ser_tx_flag = 0, ser_rx_flag = 0;
  logic irq_req, irq_ack = 0, irq_ret = 0;
  logic [15:0] irq_vec;

  int n_chk = 0, n_bad = 0, cyc = 0;
  string phase = "R1";
  bit done = 0;

  // reference model state
  int m_en, m_pr, m_req, m_vec, m_lvl, m_isr;

  always #10 clk = ~clk;

  intr_nest_ctrl i_intr_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pf_warn(pf_warn), .pf_en(pf_en),
    .ext0_flag(ext0_flag), .tmr0_flag(tmr0_flag), .ext1_flag(ext1_flag),
    .tmr1_flag(tmr1_flag), .ser_tx_flag(ser_tx_flag), .ser_rx_flag(ser_rx_flag),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret)
  );

  function automatic int flag_of(int s);
    case (s)
      0: return int'(ext0_flag);
      1: return int'(tmr0_flag);
      2: return int'(ext1_flag);
      3: return int'(tmr1_flag);
      default: return int'(ser_tx_flag | ser_rx_flag);
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_pr = 0; m_req = 0; m_vec = 0; m_lvl = 0; m_isr = 0;
    end else begin
      int best, bidx, top, nisr;
      top = 0;
      for (int l = 0; l < 3; l++) if (m_isr[l]) top = l + 1;
      nisr = m_isr;
      if (irq_ret) begin
        for (int l = 2; l >= 0; l--) if (nisr[l]) begin nisr[l] = 0; break; end
      end
      if (m_req == 0) begin
        best = 0; bidx = 0;
        if (pf_warn && pf_en) begin best = 3; bidx = 6; end
        else if (m_en[7]) begin
          for (int s = 0; s < 5; s++) begin
            if (flag_of(s) != 0 && m_en[s]) begin
              int r;
              r = m_pr[s] ? 2 : 1;
              if (r > best) begin best = r; bidx = s; end
            end
          end
        end
        if (best > top) begin m_req = 1; m_vec = bidx * 8 + 3; m_lvl = best - 1; end
      end else if (irq_ack) begin
        m_req = 0;
        nisr[m_lvl] = 1;
      end
      m_isr = nisr;
      if (reg_we) begin
        if (reg_sel) m_pr = reg_wdata & 8'h1F;
        else         m_en = reg_wdata & 8'h9F;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check(phase, int'(irq_req), m_req);
      if (m_req != 0) check(phase, int'(irq_vec), m_vec);
      check(phase, int'(reg_rdata), reg_sel ? m_pr : m_en);
    end
    if (cyc > 60000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    step();
    reg_we = 0; reg_sel = 0;
  endtask

  task automatic flags(bit e0, bit t0, bit e1, bit t1, bit tx, bit rx);
    ext0_flag = e0; tmr0_flag = t0; ext1_flag = e1; tmr1_flag = t1;
    ser_tx_flag = tx; ser_rx_flag = rx;
  endtask

  task automatic pulse_ack();
    irq_ack = 1; step(); irq_ack = 0;
  endtask

  task automatic pulse_ret();
    irq_ret = 1; step(); irq_ret = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step();
    // R1 reset and readback
    phase = "R1";
    check("R1", int'(reg_rdata), 0);
    reg_sel = 1; step(); check("R1", int'(reg_rdata), 0); reg_sel = 0;
    check("R1", int'(irq_req), 0);
    wr(0, 8'hFF); check("R1", int'(reg_rdata), 8'h9F);
    wr(1, 8'hFF); reg_sel = 1; step(); check("R1", int'(reg_rdata), 8'h1F); reg_sel = 0;
    wr(1, 8'h00);

    // R2 global enable off
    phase = "R2";
    wr(0, 8'h1F);
    flags(1, 1, 1, 1, 1, 1);
    step(3); check("R2", int'(irq_req), 0);
    pf_warn = 1; step(2); check("R2", int'(irq_req), 0);
    pf_en = 1; step(); check("R2", int'(irq_req), 1);
    check("R6", int'(irq_vec), 16'h0033);
    pulse_ack(); check("R8", int'(irq_req), 0);
    phase = "R9";
    step(2); check("R9", int'(irq_req), 0);
    pf_warn = 0; pulse_ret(); step(2); check("R9", int'(irq_req), 0);

    // R5 ties, R4 levels, R9 nesting
    phase = "R5";
    wr(0, 8'h9F);
    step(); check("R5", int'(irq_req), 1); check("R6", int'(irq_vec), 16'h0003);
    pulse_ack();
    phase = "R9";
    ext0_flag = 0; step(3); check("R9", int'(irq_req), 0);
    phase = "R4";
    wr(1, 8'h10); step(); check("R4", int'(irq_req), 1); check("R6", int'(irq_vec), 16'h0023);
    irq_ack = 1; pf_warn = 1; step(); irq_ack = 0;
    phase = "R9";
    step(); check("R9", int'(irq_req), 1); check("R9", int'(irq_vec), 16'h0033);
    pulse_ack(); pf_warn = 0;
    phase = "R10";
    pulse_ret(); pulse_ret(); step();
    check("R10", int'(irq_req), 1); check("R10", int'(irq_vec), 16'h0023);
    pulse_ack(); flags(0, 0, 0, 0, 0, 0);
    pulse_ret(); pulse_ret(); pulse_ret(); step(2);
    check("R10", int'(irq_req), 0);

    // R5 order within low level
    phase = "R5";
    wr(1, 8'h00);
    flags(0, 1, 1, 1, 1, 0); step(); check("R5", int'(irq_vec), 16'h000B);
    pulse_ack(); pulse_ret(); tmr0_flag = 0; step(); check("R5", int'(irq_vec), 16'h0013);
    pulse_ack(); pulse_ret(); ext1_flag = 0; step(); check("R5", int'(irq_vec), 16'h001B);
    pulse_ack(); flags(0, 0, 0, 0, 0, 0); pulse_ret(); step();

    // R3 per-source enables and serial OR
    phase = "R3";
    wr(0, 8'h90); ser_rx_flag = 1; step(); check("R3", int'(irq_vec), 16'h0023);
    pulse_ack(); pulse_ret(); ser_rx_flag = 0; ser_tx_flag = 1; step();
    check("R3", int'(irq_req), 1);
    pulse_ack(); pulse_ret(); ser_tx_flag = 0;
    wr(0, 8'h82); tmr1_flag = 1; step(3); check("R3", int'(irq_req), 0);
    tmr1_flag = 0;

    // R4 high beats earlier low
    phase = "R4";
    wr(0, 8'h9F); wr(1, 8'h08);
    flags(1, 0, 0, 1, 0, 0); step(); check("R4", int'(irq_vec), 16'h001B);
    pulse_ack(); flags(0, 0, 0, 0, 0, 0); pulse_ret(); step();

    // R7 hold while waiting, R8 stray ack
    phase = "R8";
    pulse_ack(); step(); check("R8", int'(irq_req), 0);
    phase = "R7";
    ext0_flag = 1; step(); check("R7", int'(irq_vec), 16'h0003);
    ext0_flag = 0; pf_warn = 1; step(3);
    check("R7", int'(irq_req), 1); check("R7", int'(irq_vec), 16'h0003);
    irq_ack = 1; pf_warn = 0; step(); irq_ack = 0; pulse_ret(); step();

    // random traffic against the model
    phase = "R9";
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r;
      r = $urandom;
      flags(r[0] & r[8], r[1] & r[9], r[2] & r[10], r[3] & r[11], r[4] & r[12], r[5] & r[13]);
      pf_warn = r[6] & r[7] & r[14];
      pf_en = r[15] | r[16];
      irq_ack = irq_req & r[17];
      irq_ret = r[18] & r[19] & r[20];
      reg_we = (r[21:24] == 4'd0);
      reg_sel = r[25];
      reg_wdata = r[31:24] | 8'h80;
      step();
    end
    reg_we = 0; irq_ack = 0; irq_ret = 0;
    step(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule